// File: doc/BRIEF.md
# Auto-Increment Register Bank with Indirect Memory Window

This block is the register side of a serial slave peripheral. A protocol engine in front of it turns bus traffic into three byte-level strobes: an address phase that selects a register, a data write, and a data read. The bank holds thirty byte-wide locations. After every data byte its register pointer steps forward, so one bus burst can sweep a run of consecutive registers.

Two locations near the top hold a 9-bit pointer into an external 512-byte synchronous memory. Two command locations above the wrap limit form a window onto that memory. Auto-increment never lands on them, so once one of them is selected by direct address it stays selected. Bytes written through the write window go to memory, and bytes read through the read window come from memory. Each memory byte moves the memory pointer on by one.

The memory read has one cycle of latency. The first byte is therefore fetched in the same cycle as the address phase that selects the read window. Each read that follows fetches the next byte, so reads can be issued every cycle. An address phase takes priority over a write in the same cycle, and a write takes priority over a read.

Top module: `autoinc_regbank`

## Requirements
- R1: After reset the register pointer is 00h, all general registers and the memory pointer are zero, and the read data is 00h.
- R2: An address phase with an address from 00h to 1Dh selects that register. An address of 1Eh or 1Fh is ignored, and the pointer keeps its value.
- R3: A write while the pointer is in 00h–19h stores the byte in that register. Registers that are not written keep their values.
- R4: The read data always shows the selected location. Each read strobe and each write strobe advances the pointer by one while it is in 00h–1Bh.
- R5: A data byte at 1Bh moves the pointer to 00h.
- R6: Location 1Ah holds memory-pointer bit 8 in bit 0, and its bits 7:1 read as 0. Location 1Bh holds memory-pointer bits 7:0. Writing 1Ah and then 1Bh in one burst loads the whole pointer.
- R7: While the pointer is 1Ch or 1Dh, data bytes do not move it.
- R8: A write at 1Ch stores the byte in memory at the memory pointer, then increments the pointer. The pointer wraps from 511 to 0.
- R9: From the cycle after 1Dh is selected, the read data is the memory byte at the memory pointer. Each read at 1Dh increments the memory pointer and presents the next byte in the next cycle, so back-to-back reads work.
- R10: Location 1Ch reads as 00h, and a read there changes neither pointer. A write at 1Dh writes no memory and leaves the memory pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_vld_i | input | 1 | Address phase strobe |
| addr_i | input | 5 | Register address for the address phase |
| wr_vld_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Write byte |
| rd_vld_i | input | 1 | Data read strobe; the host takes rd_data_o in this cycle |
| rd_data_o | output | 8 | Byte at the selected location |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 9 | Memory address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, valid the cycle after mem_en_o |

## Verification
A long write burst followed by a long read burst runs across all the general registers and the pointer pair. It separates a correct wrap at 1Bh from a pointer that runs on into the command locations. It also shows whether the unused bits of 1Ah are masked.

A stream of writes that starts at memory address 1FEh detects a memory pointer that fails to wrap at 511. It also detects a window that lets auto-increment move the pointer off 1Ch. Reading back the same region at one byte per cycle separates a correct one-cycle prefetch from stale or shifted data.

Stray traffic checks the ignore rules: out-of-range addresses, reads of 1Ch and writes of 1Dh. For each one, the memory pointer or the neighbouring bytes are read back afterwards.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int REG_AW   = 5;
  localparam int DATA_W   = 8;
  localparam int MEM_AW   = 9;
  localparam int NUM_LOCS = 30;
  // fixed decode points the host software depends on
  localparam logic [REG_AW-1:0] LOC_MPTR_HI = 5'h1A;
  localparam logic [REG_AW-1:0] LOC_MPTR_LO = 5'h1B;
  localparam logic [REG_AW-1:0] LOC_WIN_WR  = 5'h1C;
  localparam logic [REG_AW-1:0] LOC_WIN_RD  = 5'h1D;
  localparam logic [REG_AW-1:0] LOC_WRAP    = LOC_MPTR_LO;
  localparam int NUM_PLAIN = int'(LOC_MPTR_HI);
endpackage

// File: rtl/rbk_ptr.sv
module rbk_ptr #(
  parameter int                AW    = 5,
  parameter int                NLOC  = 30,
  parameter logic [AW-1:0]     LAST  = 5'h1B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic          addr_ok;

  assign addr_ok = addr_vld_i && (int'(addr_i) < NLOC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (addr_ok) begin
      ptr_q <= addr_i;
    end else if (step_i) begin
      if (ptr_q == LAST)     ptr_q <= '0;
      else if (ptr_q < LAST) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !addr_vld_i && ptr_q == LAST) |=> (ptr_q == '0));
  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !addr_vld_i && ptr_q > LAST) |=> $stable(ptr_q));
  p_addr_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && int'(addr_i) >= NLOC && !step_i) |=> $stable(ptr_q));
endmodule

// File: rtl/rbk_bank.sv
module rbk_bank #(
  parameter int AW     = 5,
  parameter int DW     = 8,
  parameter int NPLAIN = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [NPLAIN-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NPLAIN; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         regs_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == AW'(i))              regs_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NPLAIN; i++)
      if (rd_idx_i == AW'(i)) rd_data_o = regs_q[i];
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
endmodule

// File: rtl/rbk_memport.sv
module rbk_memport #(
  parameter int            AW     = 5,
  parameter int            DW     = 8,
  parameter int            MAW    = 9,
  parameter logic [AW-1:0] LOC_HI = 5'h1A,
  parameter logic [AW-1:0] LOC_LO = 5'h1B,
  parameter logic [AW-1:0] LOC_WW = 5'h1C,
  parameter logic [AW-1:0] LOC_RW = 5'h1D
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  sel_i,
  input  logic           addr_vld_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           rd_i,
  output logic [MAW-1:0] mptr_o,
  output logic [DW-1:0]  win_data_o,
  output logic           mem_en_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  localparam int HI_W = MAW - DW;

  logic [MAW-1:0] mptr_q, mptr_nxt;
  logic           wr_cmd, rd_cmd, open_rd, fetch;
  logic           fill_q;
  logic [DW-1:0]  buf_q;

  assign mptr_nxt = mptr_q + 1'b1;
  assign wr_cmd   = wr_i && sel_i == LOC_WW;
  assign rd_cmd   = rd_i && sel_i == LOC_RW;
  assign open_rd  = addr_vld_i && addr_i == LOC_RW;
  // prefetch on window open and on every consumed byte
  assign fetch    = open_rd || rd_cmd;

  assign mem_en_o    = fetch || wr_cmd;
  assign mem_we_o    = wr_cmd;
  assign mem_addr_o  = rd_cmd ? mptr_nxt : mptr_q;
  assign mem_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mptr_q <= '0;
    end else if (wr_cmd || rd_cmd) begin
      mptr_q <= mptr_nxt;
    end else if (wr_i && sel_i == LOC_HI) begin
      mptr_q[MAW-1:DW] <= wdata_i[HI_W-1:0];
    end else if (wr_i && sel_i == LOC_LO) begin
      mptr_q[DW-1:0] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      fill_q <= fetch;
      if (fill_q) buf_q <= mem_rdata_i;
    end
  end

  assign win_data_o = fill_q ? mem_rdata_i : buf_q;
  assign mptr_o     = mptr_q;

  p_we_only_win_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sel_i == LOC_WW));
  p_mptr_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && mptr_q == {MAW{1'b1}}) |=> (mptr_q == '0));
  p_rd_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd |=> (mptr_q == $past(mptr_q) + 1'b1));
  p_mptr_still_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i) |=> $stable(mptr_q));
endmodule

// File: rtl/autoinc_regbank.sv
module autoinc_regbank
  import rbk_pkg::*;
#(
  parameter int AW   = REG_AW,
  parameter int DW   = DATA_W,
  parameter int MAW  = MEM_AW,
  parameter int NLOC = NUM_LOCS
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           addr_vld_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_vld_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           rd_vld_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           mem_en_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  localparam int HI_W = MAW - DW;

  logic           wr_g, rd_g;
  logic [AW-1:0]  ptr;
  logic [DW-1:0]  bank_rdata, win_rdata;
  logic [MAW-1:0] mptr;

  // address phase beats write beats read
  assign wr_g = wr_vld_i && !addr_vld_i;
  assign rd_g = rd_vld_i && !addr_vld_i && !wr_vld_i;

  rbk_ptr #(.AW(AW), .NLOC(NLOC), .LAST(LOC_WRAP)) u_ptr (
    .clk_i, .rst_ni,
    .addr_vld_i, .addr_i,
    .step_i (wr_g || rd_g),
    .ptr_o  (ptr)
  );

  rbk_bank #(.AW(AW), .DW(DW), .NPLAIN(NUM_PLAIN)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_g && int'(ptr) < NUM_PLAIN),
    .wr_idx_i  (ptr),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (ptr),
    .rd_data_o (bank_rdata)
  );

  rbk_memport #(
    .AW(AW), .DW(DW), .MAW(MAW),
    .LOC_HI(LOC_MPTR_HI), .LOC_LO(LOC_MPTR_LO),
    .LOC_WW(LOC_WIN_WR),  .LOC_RW(LOC_WIN_RD)
  ) u_mem (
    .clk_i, .rst_ni,
    .sel_i       (ptr),
    .addr_vld_i, .addr_i,
    .wr_i        (wr_g),
    .wdata_i     (wr_data_i),
    .rd_i        (rd_g),
    .mptr_o      (mptr),
    .win_data_o  (win_rdata),
    .mem_en_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i
  );

  always_comb begin
    if (int'(ptr) < NUM_PLAIN)   rd_data_o = bank_rdata;
    else if (ptr == LOC_MPTR_HI) rd_data_o = {{(DW-HI_W){1'b0}}, mptr[MAW-1:DW]};
    else if (ptr == LOC_MPTR_LO) rd_data_o = mptr[DW-1:0];
    else if (ptr == LOC_WIN_RD)  rd_data_o = win_rdata;
    else                         rd_data_o = '0;
  end

  p_hi_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == LOC_MPTR_HI) |-> (rd_data_o[DW-1:HI_W] == '0));
  p_win_rd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == LOC_WIN_WR) |-> (rd_data_o == '0));
endmodule

// File: tb/sim_autoinc_regbank.sv
module sim_autoinc_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_vld = 1'b0, wr_vld = 1'b0, rd_vld = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       mem_en, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  autoinc_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_vld_i(addr_vld), .addr_i(addr),
    .wr_vld_i(wr_vld), .wr_data_i(wr_data),
    .rd_vld_i(rd_vld), .rd_data_o(rd_data),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // external synchronous memory
  logic [7:0] ram [512];
  initial for (int i = 0; i < 512; i++) ram[i] = 8'h00;
  initial mem_rdata = 8'h00;
  always @(posedge clk) if (mem_en) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // reference model
  int m_ptr = 0, m_mptr = 0;
  int m_reg [26];
  int m_mem [512];
  initial begin
    for (int i = 0; i < 26; i++) m_reg[i] = 0;
    for (int i = 0; i < 512; i++) m_mem[i] = 0;
  end

  function automatic int exp_rd();
    if (m_ptr < 26)  return m_reg[m_ptr];
    if (m_ptr == 26) return (m_mptr >> 8) & 1;
    if (m_ptr == 27) return m_mptr & 255;
    if (m_ptr == 29) return m_mem[m_mptr];
    return 0;
  endfunction

  function automatic void step_ptr();
    if (m_ptr == 27)     m_ptr = 0;
    else if (m_ptr < 27) m_ptr++;
  endfunction

  task automatic check(input string req);
    checks++;
    if (rd_data !== 8'(exp_rd())) begin
      failures++;
      $display("FAIL %s ptr=%0d got=%02h exp=%02h", req, m_ptr, rd_data, exp_rd());
    end
  endtask

  task automatic drive_end();
    @(posedge clk);
    #1;
    addr_vld = 0; wr_vld = 0; rd_vld = 0;
    @(negedge clk);
  endtask

  task automatic do_addr(input int a, input string req);
    addr_vld = 1; addr = 5'(a);
    #1 check(req);
    drive_end();
    if (a < 30) m_ptr = a;
  endtask

  task automatic do_wr(input int d, input string req);
    wr_vld = 1; wr_data = 8'(d);
    #1 check(req);
    drive_end();
    if (m_ptr < 26) m_reg[m_ptr] = d;
    else if (m_ptr == 26) m_mptr = (m_mptr & 255) | ((d & 1) << 8);
    else if (m_ptr == 27) m_mptr = (m_mptr & 256) | d;
    else if (m_ptr == 28) begin m_mem[m_mptr] = d; m_mptr = (m_mptr + 1) % 512; end
    step_ptr();
  endtask

  task automatic do_rd(input string req);
    rd_vld = 1;
    #1 check(req);
    drive_end();
    if (m_ptr == 29) m_mptr = (m_mptr + 1) % 512;
    step_ptr();
  endtask

  task automatic do_idle(input string req);
    #1 check(req);
    drive_end();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    do_idle("R1 reset read");
    do_rd("R1 reset reg0");
    // R3 R4: burst write all plain regs then pointer pair
    do_addr(0, "R2 select 00");
    for (int i = 0; i < 26; i++) do_wr((i * 37 + 11) & 255, "R3 burst write");
    do_wr(8'hFF, "R6 write hi");
    do_wr(8'h34, "R6 write lo");
    do_idle("R5 wrap after 1Bh write");
    for (int i = 0; i < 28; i++) do_rd("R4 burst read");
    do_idle("R5 wrap after 1Bh read");
    do_rd("R4 read 00");
    // R2: out-of-range address ignored
    do_addr(30, "R2 addr 1Eh");
    do_idle("R2 ptr kept after 1Eh");
    do_addr(31, "R2 addr 1Fh");
    do_rd("R2 ptr kept after 1Fh");
    // R8: memory writes across the 511 boundary
    do_addr(26, "R6 select hi");
    do_wr(8'h01, "R6 set hi");
    do_wr(8'hFE, "R6 set lo");
    do_addr(28, "R8 open write window");
    for (int i = 0; i < 5; i++) do_wr(8'hA0 + i, "R8 R7 stream write");
    do_rd("R10 read 1Ch");
    do_rd("R10 R7 read 1Ch again");
    do_addr(26, "R8 check hi");
    do_rd("R8 hi after wrap");
    do_rd("R8 lo after wrap");
    // R9: read back from 1FEh, back to back
    do_addr(26, "R9 set ptr");
    do_wr(8'h01, "R9 set hi");
    do_wr(8'hFE, "R9 set lo");
    do_addr(29, "R9 open read window");
    for (int i = 0; i < 4; i++) do_rd("R9 R7 back-to-back read");
    do_idle("R9 idle hold");
    do_idle("R9 idle hold 2");
    do_rd("R9 read after idle");
    // R10: write at 1Dh ignored
    do_wr(8'h55, "R10 write 1Dh");
    do_idle("R10 data after 1Dh write");
    do_rd("R10 memory untouched");
    do_addr(27, "R10 check lo");
    do_rd("R10 mptr unchanged");
    // reopen read window at 000h to confirm memory kept wrap data
    do_addr(26, "R8 set ptr 0");
    do_wr(0, "R8 hi 0");
    do_wr(0, "R8 lo 0");
    do_addr(29, "R9 reopen");
    do_rd("R8 mem 000");
    do_rd("R8 mem 001");
    do_rd("R8 mem 002");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule